// File: doc/BRIEF.md
# Configuration Space Target Decoder

This block sits behind the upstream port of a bus bridge and decides which configuration cycles the bridge itself answers. During an address phase it looks at the command code, the two lowest address bits and the per-device select strobe. When all three match a local configuration access, it raises a device-select response from the next cycle on.

It then serves one 32-bit data phase straight from a simple register-file port. Reads return the whole register. Writes touch only the enabled bytes. If the initiator signals that it wants more data phases, the block pairs the single transfer with a disconnect. Address phases presented on the downstream port are decoded with the same rules, but they are never claimed.

The register-file port is combinational in the data phase. There is no buffering: the transfer completes in the same cycle in which the initiator offers it.

Top module: `cfg_target_decoder`

## Requirements
- R1: A cycle is claimed only when the command is 4'b1010 (configuration read) or 4'b1011 (configuration write); any other code leaves `pri_devsel` low and the register port idle.
- R2: A cycle is claimed only when `pri_addr[1:0]` is 2'b00 in the address phase.
- R3: A cycle is claimed only when `pri_idsel` is high in the address phase.
- R4: An address phase on the downstream inputs is never claimed: `sec_devsel` stays low, and `pri_devsel`, `pri_trdy` and the register port do not react.
- R5: `pri_devsel` rises in the cycle after a claimed address phase. It stays high while the initiator has not offered data, and it falls in the cycle after the single transfer.
- R6: Each claimed access makes exactly one transfer. `pri_stop` is high together with `pri_trdy` when `pri_more` is high, and low otherwise. A data phase offered after the transfer gets no `pri_trdy` and no register access.
- R7: On a read, `pri_rdata` carries all 32 bits of `reg_rd_data`, whatever `pri_be_n` holds.
- R8: The register index is `pri_addr[7:2]`, captured in the address phase. On a write, `reg_wr_be` is the inverse of the active-low `pri_be_n`, and `reg_wr_data` equals `pri_wdata`.
- R9: While `pri_devsel` is high, `pri_trdy` and the register strobe follow `pri_dvld` in the same cycle, with no wait states.
- R10: During reset, `pri_devsel`, `pri_trdy`, `pri_stop`, `reg_rd_en` and `reg_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_addr_vld | input | 1 | Upstream address phase valid |
| pri_cmd | input | 4 | Upstream command code |
| pri_addr | input | 8 | Upstream address, low byte |
| pri_idsel | input | 1 | Upstream device select strobe |
| pri_dvld | input | 1 | Initiator offers a data phase |
| pri_more | input | 1 | Initiator wants further data phases |
| pri_be_n | input | 4 | Active-low byte enables |
| pri_wdata | input | 32 | Write data |
| pri_devsel | output | 1 | Cycle claimed |
| pri_trdy | output | 1 | Data transfer happens this cycle |
| pri_stop | output | 1 | Target disconnect |
| pri_rdata | output | 32 | Read data |
| sec_addr_vld | input | 1 | Downstream address phase valid |
| sec_cmd | input | 4 | Downstream command code |
| sec_addr_lo | input | 2 | Downstream address bits [1:0] |
| sec_idsel | input | 1 | Downstream device select strobe |
| sec_devsel | output | 1 | Downstream claim, always low |
| reg_idx | output | 6 | Register DWORD index |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_data | input | 32 | Register read data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_be | output | 4 | Active-high write byte mask |
| reg_wr_data | output | 32 | Register write data |

## Verification
The assertions assume that an initiator presents no new address phase while a claimed access is still open. They also assume that `pri_dvld` is only meaningful after a claim. Under these assumptions, a rise of `pri_devsel` can be traced back one cycle to a matching address phase. The stimulus keeps to this rule: every address phase is followed by its data phase and by the release of `pri_devsel` before the next one starts. Data phases without a claim, and extra data phases after the transfer, are offered on purpose, so that the bench can check that they are ignored.

// File: rtl/cfg_tgt_pkg.sv
// Shared constants and types for the configuration target decoder.
package cfg_tgt_pkg;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/cfg_addr_decode.sv
// Address-phase decoder for one bus side.
// Decides whether an address phase is a local configuration access.
// Assumes the inputs are valid only while addr_vld is high.
// ALLOW_CLAIM = 0 builds the variant for a side that may never be claimed.
module cfg_addr_decode
    import cfg_tgt_pkg::*;
#(
    parameter bit ALLOW_CLAIM = 1'b1
) (
    input  logic       addr_vld,
    input  logic [3:0] cmd,
    input  logic [1:0] addr_lo,
    input  logic       idsel,
    output logic       claim,
    output logic       is_wr
);
    logic cmd_ok;
    logic match;

    // Check the command code, the low address bits and the select strobe.
    always_comb begin
        cmd_ok = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        match  = addr_vld && cmd_ok && (addr_lo == 2'b00) && idsel;
        is_wr  = (cmd == CMD_CFG_WR);
    end

    generate
        if (ALLOW_CLAIM) begin : g_claim
            // Claim whenever the decode matches.
            always_comb claim = match;
        end else begin : g_block
            // This side never claims; the decode is only observed.
            always_comb claim = match && 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfg_dphase_ctrl.sv
// Data-phase controller: holds a claimed access open until one transfer.
// Assumes no new address phase arrives while an access is open.
// The transfer is combinational with the initiator's data-valid strobe.
module cfg_dphase_ctrl
    import cfg_tgt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic             claim_wr,
    input  logic [IDX_W-1:0] claim_idx,
    input  logic             dvld,
    input  logic             more,
    output logic             devsel,
    output logic             trdy,
    output logic             stop,
    output logic             rd_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] idx
);
    phase_t phase_q;
    logic   wr_q;

    // Open an access on a claim and close it after one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wr_q    <= 1'b0;
            idx     <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (claim) begin
                phase_q <= PH_DATA;
                wr_q    <= claim_wr;
                idx     <= claim_idx;
            end
        end else if (dvld) begin
            phase_q <= PH_IDLE;
        end
    end

    // Drive the response and the register strobes for the open access.
    always_comb begin
        devsel = (phase_q == PH_DATA);
        trdy   = devsel && dvld;
        stop   = trdy && more;
        rd_en  = trdy && !wr_q;
        wr_en  = trdy && wr_q;
    end

    // R6
    single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |=> !trdy);

    // R6
    stop_with_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> trdy);

    // R5
    devsel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel) |-> $past(trdy));

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en}));
endmodule

// File: rtl/cfg_target_decoder.sv
// Configuration space target decoder for the upstream side of a bridge.
// Claims local configuration cycles and serves one DWORD from a register
// port. Downstream address phases are decoded but never claimed.
// Assumes the register port answers reads combinationally.
module cfg_target_decoder
    import cfg_tgt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pri_addr_vld,
    input  logic [3:0]              pri_cmd,
    input  logic [ADDR_W-1:0]       pri_addr,
    input  logic                    pri_idsel,
    input  logic                    pri_dvld,
    input  logic                    pri_more,
    input  logic [DATA_W/8-1:0]     pri_be_n,
    input  logic [DATA_W-1:0]       pri_wdata,
    output logic                    pri_devsel,
    output logic                    pri_trdy,
    output logic                    pri_stop,
    output logic [DATA_W-1:0]       pri_rdata,
    input  logic                    sec_addr_vld,
    input  logic [3:0]              sec_cmd,
    input  logic [1:0]              sec_addr_lo,
    input  logic                    sec_idsel,
    output logic                    sec_devsel,
    output logic [ADDR_W-3:0]       reg_idx,
    output logic                    reg_rd_en,
    input  logic [DATA_W-1:0]       reg_rd_data,
    output logic                    reg_wr_en,
    output logic [DATA_W/8-1:0]     reg_wr_be,
    output logic [DATA_W-1:0]       reg_wr_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic pri_claim;
    logic pri_is_wr;
    logic sec_is_wr;

    cfg_addr_decode #(.ALLOW_CLAIM(1'b1)) u_pri_dec (
        .addr_vld (pri_addr_vld),
        .cmd      (pri_cmd),
        .addr_lo  (pri_addr[1:0]),
        .idsel    (pri_idsel),
        .claim    (pri_claim),
        .is_wr    (pri_is_wr)
    );

    cfg_addr_decode #(.ALLOW_CLAIM(1'b0)) u_sec_dec (
        .addr_vld (sec_addr_vld),
        .cmd      (sec_cmd),
        .addr_lo  (sec_addr_lo),
        .idsel    (sec_idsel),
        .claim    (sec_devsel),
        .is_wr    (sec_is_wr)
    );

    cfg_dphase_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (pri_claim),
        .claim_wr  (pri_is_wr),
        .claim_idx (pri_addr[ADDR_W-1:2]),
        .dvld      (pri_dvld),
        .more      (pri_more),
        .devsel    (pri_devsel),
        .trdy      (pri_trdy),
        .stop      (pri_stop),
        .rd_en     (reg_rd_en),
        .wr_en     (reg_wr_en),
        .idx       (reg_idx)
    );

    // Route write data and mask, and return the full DWORD on reads.
    always_comb begin
        reg_wr_be   = ~pri_be_n;
        reg_wr_data = pri_wdata;
        pri_rdata   = reg_rd_en ? reg_rd_data : '0;
    end

    // R1, R2, R3
    claim_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_devsel) |-> $past(pri_addr_vld && pri_idsel &&
            (pri_addr[1:0] == 2'b00) &&
            ((pri_cmd == CMD_CFG_RD) || (pri_cmd == CMD_CFG_WR))));

    // R9
    no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_devsel && pri_dvld) |-> (reg_rd_en || reg_wr_en));

    // R4
    sec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_addr_vld && !pri_addr_vld && !pri_devsel) |=> !pri_devsel);
endmodule

// File: tb/sim_cfg_target_decoder.sv
module sim_cfg_target_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pri_addr_vld = 1'b0;
    logic [3:0]  pri_cmd = 4'h0;
    logic [7:0]  pri_addr = 8'h0;
    logic        pri_idsel = 1'b0;
    logic        pri_dvld = 1'b0;
    logic        pri_more = 1'b0;
    logic [3:0]  pri_be_n = 4'hF;
    logic [31:0] pri_wdata = 32'h0;
    logic        pri_devsel, pri_trdy, pri_stop;
    logic [31:0] pri_rdata;
    logic        sec_addr_vld = 1'b0;
    logic [3:0]  sec_cmd = 4'h0;
    logic [1:0]  sec_addr_lo = 2'b00;
    logic        sec_idsel = 1'b0;
    logic        sec_devsel;
    logic [5:0]  reg_idx;
    logic        reg_rd_en, reg_wr_en;
    logic [31:0] reg_rd_data;
    logic [3:0]  reg_wr_be;
    logic [31:0] reg_wr_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    // Bench register model: each register returns a pattern carrying its index.
    assign reg_rd_data = 32'hA500_0000 | {26'd0, reg_idx};

    cfg_target_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .pri_addr_vld(pri_addr_vld), .pri_cmd(pri_cmd), .pri_addr(pri_addr),
        .pri_idsel(pri_idsel), .pri_dvld(pri_dvld), .pri_more(pri_more),
        .pri_be_n(pri_be_n), .pri_wdata(pri_wdata),
        .pri_devsel(pri_devsel), .pri_trdy(pri_trdy), .pri_stop(pri_stop),
        .pri_rdata(pri_rdata),
        .sec_addr_vld(sec_addr_vld), .sec_cmd(sec_cmd),
        .sec_addr_lo(sec_addr_lo), .sec_idsel(sec_idsel),
        .sec_devsel(sec_devsel),
        .reg_idx(reg_idx), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_be(reg_wr_be), .reg_wr_data(reg_wr_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one address phase on the chosen side, then release it.
    task automatic addr_phase(input logic sec, input logic [3:0] cmd,
                              input logic [7:0] addr, input logic idsel);
        @(negedge clk);
        if (sec) begin
            sec_addr_vld = 1'b1; sec_cmd = cmd; sec_addr_lo = addr[1:0];
            sec_idsel = idsel;
        end else begin
            pri_addr_vld = 1'b1; pri_cmd = cmd; pri_addr = addr;
            pri_idsel = idsel;
        end
        @(negedge clk);
        pri_addr_vld = 1'b0; sec_addr_vld = 1'b0;
        pri_idsel = 1'b0; sec_idsel = 1'b0;
    endtask

    // Vector: {sec, cmd[3:0], addr_lo[1:0], idsel, expect_claim}
    localparam logic [8:0] VEC [9] = '{
        {1'b0, 4'b1010, 2'b00, 1'b1, 1'b1},   // R1 cfg read
        {1'b0, 4'b1011, 2'b00, 1'b1, 1'b1},   // R1 cfg write
        {1'b0, 4'b0110, 2'b00, 1'b1, 1'b0},   // R1 memory read
        {1'b0, 4'b1110, 2'b00, 1'b1, 1'b0},   // R1 other code
        {1'b0, 4'b1010, 2'b01, 1'b1, 1'b0},   // R2 low bits 01
        {1'b0, 4'b1011, 2'b10, 1'b1, 1'b0},   // R2 low bits 10
        {1'b0, 4'b1011, 2'b00, 1'b0, 1'b0},   // R3 no select
        {1'b1, 4'b1010, 2'b00, 1'b1, 1'b0},   // R4 downstream read
        {1'b1, 4'b1011, 2'b00, 1'b1, 1'b0}    // R4 downstream write
    };

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (2) @(negedge clk);
        chk(!pri_devsel && !pri_trdy && !pri_stop && !reg_rd_en && !reg_wr_en,
            "R10", {27'd0, pri_devsel, pri_trdy, pri_stop, reg_rd_en, reg_wr_en}, 32'd0);
        pri_dvld = 1'b1;
        #1 chk(!pri_trdy && !reg_rd_en, "R10", {31'd0, pri_trdy}, 32'd0);
        pri_dvld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 9; i++) begin
            logic [8:0] v;
            logic [7:0] a;
            v = VEC[i];
            a = {6'(i + 3), v[3:2]};
            addr_phase(v[8], v[7:4], a, v[1]);
            chk(pri_devsel == v[0], "R1 R2 R3 claim", {31'd0, pri_devsel}, {31'd0, v[0]});
            chk(!sec_devsel, "R4 sec claim", {31'd0, sec_devsel}, 32'd0);
            pri_dvld = 1'b1; pri_more = 1'b0; pri_be_n = 4'b0000;
            pri_wdata = 32'h1234_0000 | i;
            #1;
            if (v[0]) begin
                chk(pri_trdy && !pri_stop && reg_idx == 6'(i + 3), "R9 R8 table xfer",
                    {pri_trdy, pri_stop, 24'd0, reg_idx}, {1'b1, 1'b0, 24'd0, 6'(i + 3)});
            end else begin
                chk(!pri_trdy && !reg_rd_en && !reg_wr_en, "R4 ignored data",
                    {29'd0, pri_trdy, reg_rd_en, reg_wr_en}, 32'd0);
            end
            @(negedge clk);
            pri_dvld = 1'b0;
            chk(!pri_devsel, "R5 release", {31'd0, pri_devsel}, 32'd0);
        end

        // R5 R9 R7: wait state, then read with all enables off
        addr_phase(1'b0, 4'b1010, {6'h2A, 2'b00}, 1'b1);
        #1 chk(pri_devsel && !pri_trdy && !reg_rd_en, "R5 hold",
            {29'd0, pri_devsel, pri_trdy, reg_rd_en}, 32'd4);
        @(negedge clk);
        chk(pri_devsel, "R5 still held", {31'd0, pri_devsel}, 32'd1);
        pri_dvld = 1'b1; pri_be_n = 4'b1111; pri_more = 1'b0;
        #1 chk(pri_trdy && reg_rd_en, "R9 read now", {30'd0, pri_trdy, reg_rd_en}, 32'd3);
        chk(pri_rdata == 32'hA500_002A, "R7 full dword", pri_rdata, 32'hA500_002A);
        chk(reg_idx == 6'h2A, "R8 index", {26'd0, reg_idx}, 32'h2A);
        @(negedge clk);
        pri_dvld = 1'b0;

        // R8 partial write
        addr_phase(1'b0, 4'b1011, {6'h05, 2'b00}, 1'b1);
        pri_dvld = 1'b1; pri_be_n = 4'b1010; pri_wdata = 32'h1122_3344;
        #1 chk(reg_wr_en && !reg_rd_en, "R8 write strobe", {30'd0, reg_wr_en, reg_rd_en}, 32'd2);
        chk(reg_wr_be == 4'b0101, "R8 mask", {28'd0, reg_wr_be}, 32'd5);
        chk(reg_wr_data == 32'h1122_3344 && reg_idx == 6'h05, "R8 data idx",
            reg_wr_data, 32'h1122_3344);
        @(negedge clk);
        pri_dvld = 1'b0;

        // R6 burst request: disconnect with the one transfer, then nothing
        addr_phase(1'b0, 4'b1010, {6'h11, 2'b00}, 1'b1);
        pri_dvld = 1'b1; pri_more = 1'b1; pri_be_n = 4'b0000;
        #1 chk(pri_trdy && pri_stop, "R6 disconnect", {30'd0, pri_trdy, pri_stop}, 32'd3);
        @(negedge clk);
        #1 chk(!pri_trdy && !reg_rd_en && !pri_devsel, "R6 no second xfer",
            {29'd0, pri_trdy, reg_rd_en, pri_devsel}, 32'd0);
        @(negedge clk);
        pri_dvld = 1'b0; pri_more = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule